// File: doc/BRIEF.md
# External Line and Pin-Change Interrupt Controller

This block turns activity on interrupt pins into request lines for a CPU interrupt unit. There are three dedicated external lines and sixteen pin-change inputs. The pin-change inputs form two groups of eight. Each of the five sources drives one request output.

External lines 0 and 1 can each trigger on a low level, on any change, on a falling edge or on a rising edge. Line 2 triggers on edges only. A pin-change group raises its request when any pin that its mask admits toggles. Every pin is detected from its pad value, so software that drives a pin as an output can raise its own interrupt.

Edge-type events set sticky pending flags. A flag clears when the CPU acknowledges it or when software writes a 1 to the matching clear strobe. A low-level request has no flag and follows the synchronized pin. A request reaches the CPU only while the global enable and the source's own enable bit are both set.

Top module: `xirq_unit`

## Requirements
- R1: After reset the sense-control register is 0, all pending flags are 0 and all requests are 0 while the pins are high.
- R2: A write of `ctrl_wdata` with `ctrl_we` high sets the sense control. Bits [1:0] set line 0 and bits [3:2] set line 1, with codes 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. Bit [4] sets line 2, with 0 = falling edge and 1 = rising edge.
- R3: In low-level mode, `irq_req[i]` is high for as long as the synchronized pin is low. It rises and falls two clock edges after the pin changes, and it sets no pending flag.
- R4: A pin change sampled at clock edge k sets the pending flag at edge k+2. A low or high pulse that lasts one clock period is still detected.
- R5: Line 2 has no level mode. While its pin is held low after its flag is cleared, the flag stays 0.
- R6: `pend[3]` is set by a toggle of any pin 7..0 whose bit is set in `pc_msk`, and `pend[4]` by pins 15..8. A pin whose mask bit is 0 has no effect.
- R7: `irq_req[i]` is `gie & src_en[i] & (pend[i] | level request)`. Pending flags are set whatever the state of `gie` and `src_en`.
- R8: `ack[i]` or `flag_clr[i]` high at an edge clears `pend[i]`. If an event for the same source occurs at that edge, the flag is set instead.
- R9: The source order of `pend`, `irq_req`, `src_en`, `ack` and `flag_clr` is: bit 0 = line 0, bit 1 = line 1, bit 2 = line 2, bit 3 = pins 7..0, bit 4 = pins 15..8.
- R10: Changing the sense mode while a pin is held steady creates no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 3 | Pad values of external lines 2..0 |
| pc_pin | input | 16 | Pad values of pin-change inputs 15..0 |
| pc_msk | input | 16 | Pin-change masks; bits 15..8 for group 1 and bits 7..0 for group 0 |
| ctrl_we | input | 1 | Write strobe for the sense control |
| ctrl_wdata | input | 5 | New sense-control value |
| gie | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enable |
| ack | input | 5 | Per-source acknowledge from the CPU |
| flag_clr | input | 5 | Per-source write-1-to-clear strobe |
| pend | output | 5 | Pending flags |
| irq_req | output | 5 | Requests toward the CPU |

## Verification
The inputs change 1 ns after a falling clock edge and are counted from the next rising edge k. A low-level request is due after edge k+1 and a pending flag after edge k+2. The directed checks therefore wait two and three falling edges, and look one edge earlier to confirm that the result is not yet present. A change to `gie` or `src_en` reaches `irq_req` with no register in between, and the check for it is made at the next falling edge. A behavioural model keeps a queue of pin samples and reads its taps at the same depths. It is compared with `pend` and `irq_req` on every falling edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int N_EXT  = 3;
  localparam int CTRL_W = 5;

  localparam logic [1:0] SNS_LOW  = 2'b00;
  localparam logic [1:0] SNS_ANY  = 2'b01;
  localparam logic [1:0] SNS_FALL = 2'b10;
  localparam logic [1:0] SNS_RISE = 2'b11;

  // event decision for one external line, from the current and previous sample
  function automatic logic sense_hit(input logic [1:0] mode, input logic cur, input logic prv);
    case (mode)
      SNS_LOW:  return 1'b0;
      SNS_ANY:  return cur ^ prv;
      SNS_FALL: return prv & ~cur;
      default:  return cur & ~prv;
    endcase
  endfunction

  // sense mode of line idx taken from the control register
  function automatic logic [1:0] line_mode(input logic [CTRL_W-1:0] c, input int idx);
    case (idx)
      0:       return c[1:0];
      1:       return c[3:2];
      default: return {1'b1, c[4]};
    endcase
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 19,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prv
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
      q_prv <= '1;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      q_prv <= stg[STAGES-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xirq_ext_line.sv
module xirq_ext_line
  import xirq_pkg::*;
#(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur,
  input  logic       prv,
  input  logic [1:0] mode,
  input  logic       clr,
  output logic       ev,
  output logic       lvl_mode,
  output logic       lvl_act,
  output logic       pend
);
  logic [1:0] eff_mode;

  assign eff_mode = LEVEL_OK ? mode : {1'b1, mode[0]};
  assign lvl_mode = (eff_mode == SNS_LOW);
  assign lvl_act  = lvl_mode & ~cur;
  assign ev       = sense_hit(eff_mode, cur, prv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~clr) | ev;
  end
endmodule

// File: rtl/xirq_pc_group.sv
module xirq_pc_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prv,
  input  logic [W-1:0] msk,
  input  logic         clr,
  output logic         ev,
  output logic         pend
);
  assign ev = |(msk & (cur ^ prv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend & ~clr) | ev;
  end
endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
  import xirq_pkg::*;
#(
  parameter int N_PC_GRP    = 2,
  parameter int PC_GRP_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [2:0]                       ext_pin,
  input  logic [N_PC_GRP*PC_GRP_W-1:0]     pc_pin,
  input  logic [N_PC_GRP*PC_GRP_W-1:0]     pc_msk,
  input  logic                             ctrl_we,
  input  logic [4:0]                       ctrl_wdata,
  input  logic                             gie,
  input  logic [3+N_PC_GRP-1:0]            src_en,
  input  logic [3+N_PC_GRP-1:0]            ack,
  input  logic [3+N_PC_GRP-1:0]            flag_clr,
  output logic [3+N_PC_GRP-1:0]            pend,
  output logic [3+N_PC_GRP-1:0]            irq_req
);
  localparam int PC_W  = N_PC_GRP * PC_GRP_W;
  localparam int N_SRC = N_EXT + N_PC_GRP;
  localparam int PIN_W = N_EXT + PC_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [PIN_W-1:0]  cur_v, prv_v;
  logic [N_SRC-1:0]  clr_v, ev_v, lvl_v;
  logic [N_EXT-1:0]  lvl_mode_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;
  end

  xirq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pc_pin, ext_pin}), .q(cur_v), .q_prv(prv_v)
  );

  assign clr_v = ack | flag_clr;

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    xirq_ext_line #(.LEVEL_OK(e < 2)) u_line (
      .clk(clk), .rst_n(rst_n), .cur(cur_v[e]), .prv(prv_v[e]),
      .mode(line_mode(ctrl_q, e)), .clr(clr_v[e]), .ev(ev_v[e]),
      .lvl_mode(lvl_mode_v[e]), .lvl_act(lvl_v[e]), .pend(pend[e])
    );
  end

  for (genvar g = 0; g < N_PC_GRP; g++) begin : g_pc
    xirq_pc_group #(.W(PC_GRP_W)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .cur(cur_v[N_EXT + g*PC_GRP_W +: PC_GRP_W]),
      .prv(prv_v[N_EXT + g*PC_GRP_W +: PC_GRP_W]),
      .msk(pc_msk[g*PC_GRP_W +: PC_GRP_W]),
      .clr(clr_v[N_EXT + g]), .ev(ev_v[N_EXT + g]), .pend(pend[N_EXT + g])
    );
    assign lvl_v[N_EXT + g] = 1'b0;
  end

  assign irq_req = {N_SRC{gie}} & src_en & (pend | lvl_v);
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk #(
  parameter int N_SRC = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic [N_SRC-1:0] clr,
  input logic [N_SRC-1:0] ev,
  input logic [N_SRC-1:0] lvl,
  input logic [1:0]       lvl_mode,
  input logic [N_SRC-1:0] src_en,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] irq_req
);
  // R7
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !gie |-> irq_req == '0);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    // R8
    ev_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) ev[i] |=> pend[i]);
    // R8
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !ev[i]) |=> !pend[i]);
    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev[i] && !clr[i]) |=> $stable(pend[i]));
    // R3
    lvl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl[i] && gie && src_en[i]) |-> irq_req[i]);
  end

  for (genvar j = 0; j < 2; j++) begin : g_lvl
    // R3
    lvl_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_mode[j] && !pend[j]) |=> !pend[j]);
  end
endmodule

bind xirq_unit xirq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .clr(clr_v), .ev(ev_v), .lvl(lvl_v),
  .lvl_mode(lvl_mode_v[1:0]), .src_en(src_en), .pend(pend), .irq_req(irq_req)
);

// File: tb/test_xirq_unit.sv
`timescale 1ns/1ps
module test_xirq_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  ext_pin = '1;
  logic [15:0] pc_pin = '1, pc_msk = '0;
  logic        ctrl_we = 1'b0, gie = 1'b0;
  logic [4:0]  ctrl_wdata = '0, src_en = '0, ack = '0, flag_clr = '0;
  logic [4:0]  pend, irq_req;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xirq_unit i_xirq_unit (.*);

  // behavioural reference: a queue of pin samples, newest first
  logic [18:0] hq[$];
  logic [4:0]  m_pend;
  logic [4:0]  m_ctrl;

  function automatic bit ev_of(input logic [1:0] m, input logic c, input logic p);
    if (m == 2'd1) return c != p;
    if (m == 2'd2) return (p == 1'b1) && (c == 1'b0);
    if (m == 2'd3) return (p == 1'b0) && (c == 1'b1);
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq.delete();
      repeat (3) hq.push_back('1);
      m_pend = '0;
      m_ctrl = '0;
    end else begin
      logic [18:0] c, p;
      logic [4:0] ev;
      c = hq[1];
      p = hq[2];
      ev = '0;
      ev[0] = ev_of(m_ctrl[1:0], c[0], p[0]);
      ev[1] = ev_of(m_ctrl[3:2], c[1], p[1]);
      ev[2] = ev_of(m_ctrl[4] ? 2'd3 : 2'd2, c[2], p[2]);
      for (int j = 0; j < 16; j++)
        if (pc_msk[j] && c[3+j] != p[3+j]) ev[3 + j/8] = 1'b1;
      m_pend = (m_pend & ~(ack | flag_clr)) | ev;
      if (ctrl_we) m_ctrl = ctrl_wdata;
      hq.push_front({pc_pin, ext_pin});
      void'(hq.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && hq.size() == 3) begin
      logic [4:0] lv, exp_req;
      lv = '0;
      lv[0] = (m_ctrl[1:0] == 2'd0) && !hq[1][0];
      lv[1] = (m_ctrl[3:2] == 2'd0) && !hq[1][1];
      exp_req = {5{gie}} & src_en & (m_pend | lv);
      chk("R4 R6 R8 model pend", pend, m_pend);
      chk("R3 R7 model irq_req", irq_req, exp_req);
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [4:0] v);
    #1 ctrl_we = 1'b1; ctrl_wdata = v;
    w(1);
    #1 ctrl_we = 1'b0;
  endtask

  task automatic pulse_clr(input logic [4:0] v, input bit use_ack);
    #1 if (use_ack) ack = v; else flag_clr = v;
    w(1);
    #1 ack = '0; flag_clr = '0;
  endtask

  initial begin
    w(3);
    #1 rst_n = 1'b1;
    w(1);
    chk("R1 pend after reset", pend, 5'h0);
    chk("R1 irq after reset", irq_req, 5'h0);
    #1 gie = 1'b1; src_en = 5'h1f;
    w(2);
    chk("R1 level mode idle with pins high", irq_req, 5'h0);

    // R3 low level on line 0
    #1 ext_pin[0] = 1'b0;
    w(1); chk("R3 level not yet", irq_req[0], 1'b0);
    w(1); chk("R3 level request", irq_req[0], 1'b1);
    chk("R3 level sets no flag", pend[0], 1'b0);
    w(3); chk("R3 level held", irq_req[0], 1'b1);
    #1 ext_pin[0] = 1'b1;
    w(2); chk("R3 level released", irq_req[0], 1'b0);

    // R2 falling edge on line 1
    wr_ctrl(5'b01000);
    #1 ext_pin[1] = 1'b0;
    w(2); chk("R4 flag not yet", pend[1], 1'b0);
    w(1); chk("R2 falling sets flag", pend[1], 1'b1);
    chk("R9 request bit 1", irq_req, 5'b00010);
    #1 ext_pin[1] = 1'b1;
    w(3); chk("R2 flag sticky after rise", pend[1], 1'b1);
    pulse_clr(5'b00010, 1'b1);
    chk("R8 ack clears", pend[1], 1'b0);

    // R2 rising on line 1, R4 one-cycle low pulse
    wr_ctrl(5'b01100);
    #1 ext_pin[1] = 1'b0;
    w(1);
    #1 ext_pin[1] = 1'b1;
    w(2); chk("R4 pulse falling part ignored", pend[1], 1'b0);
    w(1); chk("R4 short pulse rising caught", pend[1], 1'b1);
    pulse_clr(5'b00010, 1'b0);
    chk("R8 write-1 clear", pend[1], 1'b0);

    // R2 any change on line 0
    wr_ctrl(5'b00001);
    #1 ext_pin[0] = 1'b0;
    w(3); chk("R2 toggle fall", pend[0], 1'b1);
    pulse_clr(5'b00001, 1'b1);
    #1 ext_pin[0] = 1'b1;
    w(3); chk("R2 toggle rise", pend[0], 1'b1);
    pulse_clr(5'b00001, 1'b1);

    // R5 line 2
    wr_ctrl(5'b01010);
    #1 ext_pin[2] = 1'b0;
    w(3); chk("R5 line2 falling", pend[2], 1'b1);
    pulse_clr(5'b00100, 1'b0);
    w(3); chk("R5 line2 no level", pend[2], 1'b0);
    chk("R5 line2 no level request", irq_req[2], 1'b0);
    wr_ctrl(5'b11010);
    #1 ext_pin[2] = 1'b1;
    w(3); chk("R5 line2 rising", pend[2], 1'b1);

    // R7 gating
    #1 gie = 1'b0;
    w(1); chk("R7 gie off", irq_req[2], 1'b0);
    chk("R7 flag kept", pend[2], 1'b1);
    #1 gie = 1'b1; src_en[2] = 1'b0;
    w(1); chk("R7 source disabled", irq_req[2], 1'b0);
    #1 src_en[2] = 1'b1;
    w(1); chk("R7 both enabled", irq_req[2], 1'b1);
    pulse_clr(5'b00100, 1'b1);

    // R6 pin-change groups
    #1 pc_msk = 16'h8001; pc_pin[1] = 1'b0;
    w(4); chk("R6 masked pin ignored", pend[4:3], 2'b00);
    #1 pc_pin[0] = 1'b0;
    w(3); chk("R6 group 0 toggle", pend[4:3], 2'b01);
    #1 pc_pin[15] = 1'b0;
    w(3); chk("R6 group 1 toggle", pend[4:3], 2'b11);
    chk("R9 group requests", irq_req[4:3], 2'b11);
    pulse_clr(5'b11000, 1'b0);
    chk("R6 groups cleared", pend[4:3], 2'b00);

    // R10 mode change on a steady low pin
    wr_ctrl(5'b10010);
    #1 ext_pin[1] = 1'b0;
    w(4); chk("R10 level before switch", irq_req[1], 1'b1);
    wr_ctrl(5'b11010);
    w(3); chk("R10 no spurious flag", pend[1], 1'b0);
    chk("R10 request gone", irq_req[1], 1'b0);
    #1 ext_pin[1] = 1'b1;
    w(3); pulse_clr(5'b00010, 1'b1);

    // R8 event wins over ack in the same cycle (line 1 any change)
    wr_ctrl(5'b10110);
    #1 ext_pin[1] = 1'b0;
    w(2);
    #1 ack = 5'b00010;
    w(1); chk("R8 set wins over ack", pend[1], 1'b1);
    #1 ack = '0;
    w(2);
    pulse_clr(5'b00010, 1'b1);
    chk("R8 later ack clears", pend[1], 1'b0);

    w(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule